// File: doc/BRIEF.md
# Three-Phase Minimum Dead-Time Inserter

This block sits between a motor controller's PWM generator and the gate drivers of three half-bridges. Each phase has separate high-side and low-side PWM commands. The block turns each command into a registered gate-on output. It guarantees that a switch never turns on until its complementary switch has been off for at least a programmed number of clock cycles.

The dead time acts only as a floor. The gap is counted from the moment the opposite gate is actually seen to fall. If the controller already leaves a gap at least as long as the programmed floor, the edge passes through with its normal one-cycle latency and no delay is added.

The block also enforces a minimum gate-on pulse. When both commands of a phase are asserted together, it holds both gates of that phase off. A force-off input or a cleared enable shuts every gate on the next clock edge. The dead-time code is loaded only while the block is disabled. All timing is counted in cycles of the block clock; one code step is five cycles.

Top module: `dt_insert_top`

## Requirements
- R1: While synchronous reset is high, all six gate outputs are low at every clock edge, whatever the commands are.
- R2: When the opposite gate of a phase has been off for longer than the dead time, a rising command appears on its gate output at the next clock edge.
- R3: The dead time in cycles is (code+1)*5 for codes 0 to 9. Codes above 9 act as code 9. A gate may rise no earlier than that many cycles after the complementary gate of the same phase falls. When the command is already waiting, it rises exactly that many cycles after the fall.
- R4: When the commanded gap between one command falling and the complementary command rising is already at least the dead time, the gate-to-gate gap equals the commanded gap and no delay is added.
- R5: Once a gate turns on, it stays on for at least 5 cycles, even if its command is a single cycle long, unless R6 or R7 applies.
- R6: When both commands of a phase are high, both gates of that phase are low at the next edge and stay low until one command drops.
- R7: Asserting force-off or clearing enable drives all six gates low at the next clock edge. This overrides the dead-time logic and the minimum-on hold.
- R8: The dead-time code is sampled only while enable is low. A code change while enabled has no effect on the dead time.
- R9: The high and low gates of a phase are never on in the same cycle.
- R10: All three phases, and both directions (high-to-low and low-to-high), produce identical dead times and latencies for identical commands.
- R11: Once the minimum-on time has elapsed, a falling command turns its gate off at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Gate enable; low forces all gates off and loads the dead-time code |
| force_off_i | input | 1 | Global force-off of all gates |
| dt_code_i | input | 4 | Dead-time setting code |
| pwm_hi_i | input | 3 | High-side PWM command, one bit per phase |
| pwm_lo_i | input | 3 | Low-side PWM command, one bit per phase |
| gate_hi_o | output | 3 | High-side gate-on outputs |
| gate_lo_o | output | 3 | Low-side gate-on outputs |

## Verification
The hardest case to reach is the boundary between a gap the block must stretch and a gap it must leave alone. The stimulus therefore drops one command and raises the complementary one a chosen number of cycles later: zero, just below the floor, exactly on it and beyond it. It then counts the cycles from one gate falling to the other rising, for every phase and in both directions. Saturation of out-of-range codes and a code change made while enabled are reached the same way, by reprogramming through the enable input before a gap is measured.

// File: rtl/dt_pkg.sv
package dt_pkg;

    // Per-phase command pair carried between the top and each phase slice
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_pair_t;

    // Converts a setting code into a dead-time length in clock cycles,
    // saturating codes above the highest legal one.
    function automatic int unsigned code_cycles(
        input int unsigned code,
        input int unsigned step,
        input int unsigned max_code
    );
        int unsigned c;
        c = (code > max_code) ? max_code : code;
        return (c + 1) * step;
    endfunction

    // Width that holds the longest dead time
    function automatic int unsigned cyc_width(
        input int unsigned step,
        input int unsigned max_code
    );
        return $clog2((max_code + 1) * step + 1);
    endfunction

endpackage

// File: rtl/dt_setting.sv
module dt_setting #(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned STEP_CYC = 5,
    parameter int unsigned MAX_CODE = 9,
    parameter int unsigned CNT_W    = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              enable_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  dt_cyc_o
);
    import dt_pkg::*;

    logic [CNT_W-1:0] dt_q;
    logic [CNT_W-1:0] dt_new;

    always_comb begin
        dt_new = CNT_W'(code_cycles(32'(code_i), STEP_CYC, MAX_CODE));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dt_q <= CNT_W'(STEP_CYC);
        end else if (!enable_i) begin
            dt_q <= dt_new;
        end
    end

    assign dt_cyc_o = dt_q;

    // R8: the setting is frozen while the block is enabled
    p_setting_frozen_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        enable_i |=> $stable(dt_cyc_o));

endmodule

// File: rtl/dt_leg.sv
module dt_leg #(
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned MIN_ON_CYC = 5
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             kill_i,
    input  logic             cmd_i,
    input  logic             conflict_i,
    input  logic             other_on_i,
    input  logic             other_gap_ok_i,
    input  logic [CNT_W-1:0] dt_cyc_i,
    output logic             gate_o,
    output logic             gap_ok_o
);
    localparam int unsigned HOLD_W = (MIN_ON_CYC > 1) ? $clog2(MIN_ON_CYC + 1) : 1;

    logic              on_q;
    logic              on_d;
    logic [CNT_W-1:0]  off_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              hold;
    logic              turn_on;
    logic              stay_on;

    always_comb begin
        hold    = (hold_cnt != '0);
        turn_on = !on_q && cmd_i && !conflict_i && !other_on_i && other_gap_ok_i;
        stay_on = on_q && (cmd_i || hold) && !conflict_i;
        on_d    = !kill_i && (turn_on || stay_on);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            on_q     <= 1'b0;
            off_cnt  <= '1;
            hold_cnt <= '0;
        end else begin
            on_q <= on_d;
            if (on_q) begin
                off_cnt <= '0;
            end else if (off_cnt != '1) begin
                off_cnt <= off_cnt + CNT_W'(1);
            end
            if (!on_d) begin
                hold_cnt <= '0;
            end else if (turn_on) begin
                hold_cnt <= HOLD_W'(MIN_ON_CYC - 1);
            end else if (hold) begin
                hold_cnt <= hold_cnt - HOLD_W'(1);
            end
        end
    end

    // The opposite leg may rise at the next edge once this count covers the floor
    assign gap_ok_o = !on_q &&
        (({1'b0, off_cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, dt_cyc_i});
    assign gate_o   = on_q;

    // R7: kill forces the gate off at the next edge
    p_kill_off_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        kill_i |=> !gate_o);

    // R5: a gate only drops early when killed or in conflict
    p_min_on_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(gate_o) |-> ($past(hold_cnt) == '0 || $past(kill_i) || $past(conflict_i)));

    // R3: a rising gate saw the opposite gate off long enough
    p_gap_floor_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(gate_o) |-> ($past(other_gap_ok_i) && !$past(other_on_i)));

endmodule

// File: rtl/dt_phase.sv
module dt_phase #(
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned MIN_ON_CYC = 5
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               kill_i,
    input  dt_pkg::leg_pair_t  cmd_i,
    input  logic [CNT_W-1:0]   dt_cyc_i,
    output dt_pkg::leg_pair_t  gate_o
);
    import dt_pkg::*;

    logic conflict;
    logic hi_ok;
    logic lo_ok;
    logic hi_on;
    logic lo_on;

    assign conflict = cmd_i.hi && cmd_i.lo;

    dt_leg #(.CNT_W(CNT_W), .MIN_ON_CYC(MIN_ON_CYC)) u_hi (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .kill_i         (kill_i),
        .cmd_i          (cmd_i.hi),
        .conflict_i     (conflict),
        .other_on_i     (lo_on),
        .other_gap_ok_i (lo_ok),
        .dt_cyc_i       (dt_cyc_i),
        .gate_o         (hi_on),
        .gap_ok_o       (hi_ok)
    );

    dt_leg #(.CNT_W(CNT_W), .MIN_ON_CYC(MIN_ON_CYC)) u_lo (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .kill_i         (kill_i),
        .cmd_i          (cmd_i.lo),
        .conflict_i     (conflict),
        .other_on_i     (hi_on),
        .other_gap_ok_i (hi_ok),
        .dt_cyc_i       (dt_cyc_i),
        .gate_o         (lo_on),
        .gap_ok_o       (lo_ok)
    );

    assign gate_o.hi = hi_on;
    assign gate_o.lo = lo_on;

    // R9: never both switches of a half-bridge on
    p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hi_on && lo_on));

    // R6: contradictory commands turn the whole phase off
    p_conflict_off_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        conflict |=> (!hi_on && !lo_on));

endmodule

// File: rtl/dt_insert_top.sv
module dt_insert_top #(
    parameter int unsigned NUM_PH     = 3,
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned STEP_CYC   = 5,
    parameter int unsigned MAX_CODE   = 9,
    parameter int unsigned MIN_ON_CYC = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              enable_i,
    input  logic              force_off_i,
    input  logic [CODE_W-1:0] dt_code_i,
    input  logic [NUM_PH-1:0] pwm_hi_i,
    input  logic [NUM_PH-1:0] pwm_lo_i,
    output logic [NUM_PH-1:0] gate_hi_o,
    output logic [NUM_PH-1:0] gate_lo_o
);
    import dt_pkg::*;

    localparam int unsigned CNT_W = cyc_width(STEP_CYC, MAX_CODE);

    logic [CNT_W-1:0] dt_cyc;
    logic             kill;

    assign kill = force_off_i || !enable_i;

    dt_setting #(
        .CODE_W   (CODE_W),
        .STEP_CYC (STEP_CYC),
        .MAX_CODE (MAX_CODE),
        .CNT_W    (CNT_W)
    ) u_setting (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .enable_i (enable_i),
        .code_i   (dt_code_i),
        .dt_cyc_o (dt_cyc)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        leg_pair_t cmd;
        leg_pair_t gate;

        assign cmd.hi = pwm_hi_i[p];
        assign cmd.lo = pwm_lo_i[p];

        dt_phase #(.CNT_W(CNT_W), .MIN_ON_CYC(MIN_ON_CYC)) u_phase (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .kill_i   (kill),
            .cmd_i    (cmd),
            .dt_cyc_i (dt_cyc),
            .gate_o   (gate)
        );

        assign gate_hi_o[p] = gate.hi;
        assign gate_lo_o[p] = gate.lo;
    end

    // R1: reset leaves every gate off
    p_reset_off_r1: assert property (@(posedge clk_i)
        rst_i |=> (gate_hi_o == '0 && gate_lo_o == '0));

endmodule

// File: tb/tb_dt_insert_top.sv
module tb_dt_insert_top;

    localparam int NPH = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           enable = 1'b0;
    logic           force_off = 1'b0;
    logic [3:0]     code = 4'd0;
    logic [NPH-1:0] hi = '0;
    logic [NPH-1:0] lo = '0;
    logic [NPH-1:0] ghi;
    logic [NPH-1:0] glo;

    int n_checks = 0;
    int n_errors = 0;
    int overlap_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dt_insert_top dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .enable_i    (enable),
        .force_off_i (force_off),
        .dt_code_i   (code),
        .pwm_hi_i    (hi),
        .pwm_lo_i    (lo),
        .gate_hi_o   (ghi),
        .gate_lo_o   (glo)
    );

    // Vector: dir, code, commanded gap, expected gate gap
    // dir 0: high side on first, then low side; dir 1: reverse
    localparam int NVEC = 11;
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 4'd0,  8'd0,  8'd5},
        {1'b1, 4'd0,  8'd3,  8'd5},
        {1'b0, 4'd0,  8'd5,  8'd5},
        {1'b0, 4'd0,  8'd8,  8'd8},
        {1'b1, 4'd3,  8'd0,  8'd20},
        {1'b0, 4'd3,  8'd19, 8'd20},
        {1'b1, 4'd3,  8'd25, 8'd25},
        {1'b0, 4'd9,  8'd0,  8'd50},
        {1'b1, 4'd9,  8'd60, 8'd60},
        {1'b0, 4'd12, 8'd0,  8'd50},
        {1'b1, 4'd5,  8'd10, 8'd30}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && ((ghi & glo) != '0)) overlap_seen++;
    end

    task automatic set_side(input bit dir, input bit first, input logic [NPH-1:0] v);
        if ((dir == 1'b0) == first) hi = v;
        else lo = v;
    endtask

    function automatic logic [NPH-1:0] side_gate(input bit dir, input bit first);
        return ((dir == 1'b0) == first) ? ghi : glo;
    endfunction

    task automatic run_gap(input bit dir, input logic [3:0] c, input int g,
                           input int exp, input bit reconfig);
        int seen [NPH];
        int cnt;
        bit pending;
        if (reconfig) begin
            enable = 1'b0;
            code = c;
            repeat (64) @(negedge clk);
            enable = 1'b1;
        end
        set_side(dir, 1'b1, '1);
        @(negedge clk);
        // R2: first gate rises at the next edge
        check(side_gate(dir, 1'b1) == '1, "R2", side_gate(dir, 1'b1), 7);
        repeat (19) @(negedge clk);
        set_side(dir, 1'b1, '0);
        if (g == 0) set_side(dir, 1'b0, '1);
        @(negedge clk);
        // R11: gate follows falling command at next edge
        check(side_gate(dir, 1'b1) == '0, "R11", side_gate(dir, 1'b1), 0);
        for (int p = 0; p < NPH; p++) seen[p] = -1;
        cnt = 0;
        pending = 1'b1;
        while (pending && cnt < 200) begin
            if (g > 0 && cnt == g - 1) set_side(dir, 1'b0, '1);
            @(negedge clk);
            cnt++;
            pending = 1'b0;
            for (int p = 0; p < NPH; p++) begin
                if (seen[p] < 0 && side_gate(dir, 1'b0)[p]) seen[p] = cnt;
                if (seen[p] < 0) pending = 1'b1;
            end
        end
        for (int p = 0; p < NPH; p++) begin
            if (g >= exp) check(seen[p] == exp, "R4 kept gap", seen[p], exp);
            else          check(seen[p] == exp, "R3 dead time", seen[p], exp);
        end
        // R10: phases agree
        check(seen[0] == seen[1] && seen[1] == seen[2], "R10 phase match", seen[2], seen[0]);
        hi = '0;
        lo = '0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int width;
        // R1: reset with active commands
        enable = 1'b1;
        hi = '1;
        repeat (4) @(negedge clk);
        check(ghi == '0 && glo == '0, "R1 reset", {ghi, glo}, 0);
        hi = '0;
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R2: immediate turn-on from idle
        hi = '1;
        @(negedge clk);
        check(ghi == '1, "R2 first on", ghi, 7);

        // R6: conflicting commands
        repeat (6) @(negedge clk);
        lo = '1;
        @(negedge clk);
        check(ghi == '0 && glo == '0, "R6 conflict off", {ghi, glo}, 0);
        repeat (8) @(negedge clk);
        check(ghi == '0 && glo == '0, "R6 conflict hold", {ghi, glo}, 0);
        lo = '0;
        @(negedge clk);
        check(ghi == '1, "R6 release", ghi, 7);

        // R7: force-off and disable
        repeat (6) @(negedge clk);
        force_off = 1'b1;
        @(negedge clk);
        check(ghi == '0, "R7 force-off", ghi, 0);
        force_off = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(ghi == '0, "R7 disable", ghi, 0);
        hi = '0;
        code = 4'd0;
        repeat (64) @(negedge clk);
        enable = 1'b1;
        repeat (4) @(negedge clk);

        // R5: single-cycle command gives a 5-cycle gate pulse
        hi = '1;
        @(negedge clk);
        hi = '0;
        width = 0;
        while (ghi == '1 && width < 50) begin
            width++;
            @(negedge clk);
        end
        check(width == 5, "R5 min on", width, 5);
        repeat (10) @(negedge clk);

        // R7: kill overrides the minimum-on hold
        lo = '1;
        @(negedge clk);
        lo = '0;
        @(negedge clk);
        force_off = 1'b1;
        @(negedge clk);
        check(glo == '0, "R7 kill during hold", glo, 0);
        force_off = 1'b0;
        repeat (64) @(negedge clk);

        // Table of gap vectors
        for (int i = 0; i < NVEC; i++) begin
            run_gap(VEC[i][20], VEC[i][19:16], int'(VEC[i][15:8]), int'(VEC[i][7:0]), 1'b1);
        end

        // R8: a code change while enabled is ignored
        enable = 1'b0;
        code = 4'd0;
        repeat (64) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        code = 4'd9;
        repeat (4) @(negedge clk);
        run_gap(1'b0, 4'd9, 0, 5, 1'b0);
        run_gap(1'b1, 4'd9, 0, 5, 1'b0);

        // R9: no overlap over the whole run
        check(overlap_seen == 0, "R9 no overlap", overlap_seen, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule